// File: doc/BRIEF.md
# Phase-Shifted Full-Bridge PWM Generator

This block produces the four gate-drive logic signals for a full bridge from a digital timebase. A period counter sets the switching period. The first leg (outputs A and B) switches in step with that period. Each of its outputs is high for about half the period. The second leg (outputs C and D) has the same waveform, delayed by a phase shift that comes from a command word. The delay runs from zero, where both legs switch together, to half a period, which is 180 degrees. Power transfer is controlled only through this shift. The duty cycle of each leg stays fixed.

Each output waits a programmed dead time after its partner in the same leg turns off before it turns on. Turn-off has no added delay. The two legs take separate dead-time counts. Small phase commands snap to exactly zero shift, and large commands saturate at 180 degrees. A new command takes effect only at a period boundary. A force-low input holds all four outputs low. A one-cycle strobe marks the start of each period.

Top module: `psfb_pwm`

## Requirements
- R1: `period_start` is high for exactly one clock every 2*H clocks, where H = `period_len`>>1, raised to 2 if smaller. `period_start` also marks k = 0 for the cycle index k used in R2 to R4.
- R2: In the A/B leg, the undelayed phase is A for k in [0,H) and B for k in [H,2H). `out_a` and `out_b` are never high in the same cycle.
- R3: `out_a` is high exactly for k in [Da,H) and `out_b` exactly for k in [H+Da,2H), with Da = `dead_ab`. Turn-on is delayed and turn-off is not.
- R4: The C/D leg uses position p = (k - S) mod 2H, where S is the latched shift. `out_c` is high for p in [Dc,H) and `out_d` for p in [H+Dc,2H), with Dc = `dead_cd`.
- R5: The two dead-time counts are applied independently: `dead_ab` only affects A/B, and `dead_cd` only affects C/D.
- R6: A dead-time count of 0 behaves as a count of 1, so every turn-on follows at least one clock after the partner has turned off.
- R7: A phase command below ZERO_TH (16 by default) gives S = 0, with both legs switching together.
- R8: A phase command of ZERO_TH or more gives S = command - ZERO_TH, clamped at H (180 degrees).
- R9: The phase command is sampled only at the clock edge that starts a new period. A change made during a period leaves the rest of that period unaffected.
- R10: One clock after `force_low` is sampled high, all four outputs are low, and they stay low while it stays high. Normal switching, with dead time, resumes after it is released.
- R11: While `rst_n` is low, all four outputs and `period_start` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| period_len | input | CNT_W | Switching period in clocks (bit 0 ignored, minimum 4) |
| phase_cmd | input | PH_W | Phase-shift command |
| dead_ab | input | DT_W | Turn-on dead time of the A/B leg in clocks |
| dead_cd | input | DT_W | Turn-on dead time of the C/D leg in clocks |
| force_low | input | 1 | Holds all outputs low while high |
| out_a | output | 1 | Leg 1 high-side drive |
| out_b | output | 1 | Leg 1 low-side drive |
| out_c | output | 1 | Leg 2 high-side drive |
| out_d | output | 1 | Leg 2 low-side drive |
| period_start | output | 1 | One-clock strobe at the start of each period |

## Verification
The assertions check the following on every cycle:
- The two outputs of a leg are never high together, and no output rises in the cycle right after its partner was high.
- The strobe is a single-cycle pulse.
- The force-low input blanks all four outputs.
- The latched shift never exceeds half a period, is zero for sub-threshold commands, and changes only at a period boundary.

Only the bench's sweeps show the exact edge positions. The bench compares every output in every cycle of a period against positions it computes itself. It does this over several period lengths, the full range of phase commands including the zero and clamp regions, and several pairs of dead times. It also checks the mid-period command change and recovery from force-low.

// File: rtl/psfb_pkg.sv
package psfb_pkg;

  // Drive pair of one bridge leg: hi = upper switch, lo = lower switch.
  typedef struct packed {
    logic hi;
    logic lo;
  } leg_drive_t;

  localparam int NUM_LEGS = 2;

endpackage

// File: rtl/psfb_rst_sync.sv
module psfb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/psfb_timebase.sv
module psfb_timebase #(
  parameter int CNT_W   = 8,
  parameter int PH_W    = 8,
  parameter int ZERO_TH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period_len,
  input  logic [PH_W-1:0]  phase_cmd,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] half,
  output logic [CNT_W-1:0] shift,
  output logic             wrap
);

  localparam int MW = ((PH_W > CNT_W) ? PH_W : CNT_W) + 1;

  logic [CNT_W-1:0] half_raw;
  logic [CNT_W-1:0] last;
  logic [CNT_W-1:0] cnt_nxt;
  logic [CNT_W-1:0] shift_nxt;
  logic [MW-1:0]    cmd_w;
  logic [MW-1:0]    excess;

  // Half period, floored at two clocks.
  always_comb begin
    half_raw = {1'b0, period_len[CNT_W-1:1]};
    half     = (half_raw < CNT_W'(2)) ? CNT_W'(2) : half_raw;
    last     = {half[CNT_W-2:0], 1'b0} - CNT_W'(1);
    wrap     = (cnt >= last);
  end

  always_comb begin
    cnt_nxt = wrap ? '0 : cnt + CNT_W'(1);
  end

  // Phase command to shift in clocks: dead zone, offset, clamp.
  always_comb begin
    cmd_w  = MW'(phase_cmd);
    excess = cmd_w - MW'(ZERO_TH);
    if (cmd_w < MW'(ZERO_TH))      shift_nxt = '0;
    else if (excess > MW'(half))   shift_nxt = half;
    else                           shift_nxt = excess[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    shift <= '0;
    else if (wrap) shift <= shift_nxt;
  end

  assert_shift_clamped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (shift <= $past(half)));

  assert_dead_zone_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && (MW'(phase_cmd) < MW'(ZERO_TH))) |=> (shift == '0));

  assert_shift_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(shift));

endmodule

// File: rtl/psfb_dead_gate.sv
module psfb_dead_gate #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             raw,
  input  logic [CNT_W-1:0] dead,
  output logic             gate
);

  logic [CNT_W-1:0] age;
  logic [CNT_W-1:0] age_nxt;

  // age counts the cycles raw has already been high, saturating.
  always_comb begin
    if (clr || !raw)    age_nxt = '0;
    else if (&age)      age_nxt = age;
    else                age_nxt = age + CNT_W'(1);
    gate = raw && !clr && (age >= dead);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else        age <= age_nxt;
  end

endmodule

// File: rtl/psfb_leg.sv
module psfb_leg
  import psfb_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             force_low,
  input  logic [CNT_W-1:0] pos,
  input  logic [CNT_W-1:0] half,
  input  logic [CNT_W-1:0] dead,
  output leg_drive_t       drv
);

  logic [1:0] raw;
  logic [1:0] gate;
  leg_drive_t drv_nxt;

  assign raw[1] = (pos < half);
  assign raw[0] = !raw[1];

  for (genvar s = 0; s < 2; s++) begin : g_side
    psfb_dead_gate #(.CNT_W(CNT_W)) i_gate (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (force_low),
      .raw   (raw[s]),
      .dead  (dead),
      .gate  (gate[s])
    );
  end

  always_comb begin
    drv_nxt.hi = gate[1] && !force_low;
    drv_nxt.lo = gate[0] && !force_low;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drv <= '0;
    else        drv <= drv_nxt;
  end

  assert_no_overlap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(drv.hi && drv.lo));

  assert_hi_turn_on_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv.hi) |-> !$past(drv.lo));

  assert_lo_turn_on_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv.lo) |-> !$past(drv.hi));

endmodule

// File: rtl/psfb_pwm.sv
module psfb_pwm
  import psfb_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int PH_W    = 8,
  parameter int DT_W    = 4,
  parameter int ZERO_TH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period_len,
  input  logic [PH_W-1:0]  phase_cmd,
  input  logic [DT_W-1:0]  dead_ab,
  input  logic [DT_W-1:0]  dead_cd,
  input  logic             force_low,
  output logic             out_a,
  output logic             out_b,
  output logic             out_c,
  output logic             out_d,
  output logic             period_start
);

  logic             rst_sync_n;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] half;
  logic [CNT_W-1:0] shift;
  logic             wrap;
  logic [CNT_W:0]   pos_wide;
  logic [CNT_W-1:0] pos   [NUM_LEGS];
  logic [CNT_W-1:0] dead  [NUM_LEGS];
  leg_drive_t       drv   [NUM_LEGS];
  logic             strobe_nxt;

  psfb_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  psfb_timebase #(.CNT_W(CNT_W), .PH_W(PH_W), .ZERO_TH(ZERO_TH)) i_timebase (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .period_len (period_len),
    .phase_cmd  (phase_cmd),
    .cnt        (cnt),
    .half       (half),
    .shift      (shift),
    .wrap       (wrap)
  );

  // Lagging leg position: (cnt - shift) mod 2*half.
  always_comb begin
    pos_wide = {1'b0, cnt} - {1'b0, shift};
    if (cnt < shift) pos_wide = pos_wide + {half, 1'b0};
    pos[0] = cnt;
    pos[1] = pos_wide[CNT_W-1:0];
  end

  // Zero dead time is raised to the one-clock minimum.
  always_comb begin
    dead[0] = (dead_ab == '0) ? CNT_W'(1) : CNT_W'(dead_ab);
    dead[1] = (dead_cd == '0) ? CNT_W'(1) : CNT_W'(dead_cd);
  end

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    psfb_leg #(.CNT_W(CNT_W)) i_leg (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .force_low (force_low),
      .pos       (pos[g]),
      .half      (half),
      .dead      (dead[g]),
      .drv       (drv[g])
    );
  end

  assign strobe_nxt = (cnt == '0);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) period_start <= 1'b0;
    else             period_start <= strobe_nxt;
  end

  assign out_a = drv[0].hi;
  assign out_b = drv[0].lo;
  assign out_c = drv[1].hi;
  assign out_d = drv[1].lo;

  assert_strobe_single_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    period_start |=> !period_start);

  assert_force_low_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    force_low |=> !(out_a || out_b || out_c || out_d));

  assert_reset_quiet_R11: assert property (@(posedge clk)
    !rst_n |-> !(out_a || out_b || out_c || out_d || period_start));

endmodule

// File: tb/test_psfb_pwm.sv
module test_psfb_pwm;

  localparam int CNT_W = 8;
  localparam int PH_W  = 8;
  localparam int DT_W  = 4;
  localparam int ZTH   = 16;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [CNT_W-1:0] period_len;
  logic [PH_W-1:0]  phase_cmd;
  logic [DT_W-1:0]  dead_ab;
  logic [DT_W-1:0]  dead_cd;
  logic             force_low;
  logic             out_a, out_b, out_c, out_d, period_start;

  int n_vec  = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  psfb_pwm #(.CNT_W(CNT_W), .PH_W(PH_W), .DT_W(DT_W), .ZERO_TH(ZTH)) i_psfb_pwm (
    .clk(clk), .rst_n(rst_n), .period_len(period_len), .phase_cmd(phase_cmd),
    .dead_ab(dead_ab), .dead_cd(dead_cd), .force_low(force_low),
    .out_a(out_a), .out_b(out_b), .out_c(out_c), .out_d(out_d),
    .period_start(period_start)
  );

  always @(posedge clk) cycles <= cycles + 1;

  initial begin
    wait (cycles >= 190000 || done);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<190000", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  function automatic int dmap(input int dt);
    return (dt == 0) ? 1 : dt;
  endfunction

  function automatic int smap(input int cmd, input int h);
    if (cmd < ZTH) return 0;
    if (cmd - ZTH > h) return h;
    return cmd - ZTH;
  endfunction

  task automatic wait_ps();
    do @(negedge clk); while (!period_start && cycles < 190000);
  endtask

  // Called at the negedge where period_start is high (k = 0).
  task automatic check_period(input int h, input int s, input int dta, input int dtc,
                              input string ra, input string rc);
    int da = dmap(dta);
    int dc = dmap(dtc);
    for (int k = 0; k < 2 * h; k++) begin
      int p = (k - s + 2 * h) % (2 * h);
      if (k != 0) @(negedge clk);
      chk(period_start, (k == 0), "R1", $sformatf("strobe k=%0d", k));
      chk(out_a, (k < h) && (k >= da), ra, $sformatf("out_a k=%0d h=%0d d=%0d", k, h, da));
      chk(out_b, (k >= h) && (k - h >= da), "R2", $sformatf("out_b k=%0d h=%0d d=%0d", k, h, da));
      chk(out_c, (p < h) && (p >= dc), rc, $sformatf("out_c k=%0d s=%0d d=%0d", k, s, dc));
      chk(out_d, (p >= h) && (p - h >= dc), rc, $sformatf("out_d k=%0d s=%0d d=%0d", k, s, dc));
    end
  endtask

  task automatic do_reset(input int plen);
    rst_n = 1'b0;
    period_len = CNT_W'(plen);
    repeat (3) @(negedge clk);
    chk(out_a, 1'b0, "R11", "out_a in reset");
    chk(out_b, 1'b0, "R11", "out_b in reset");
    chk(out_c, 1'b0, "R11", "out_c in reset");
    chk(out_d, 1'b0, "R11", "out_d in reset");
    chk(period_start, 1'b0, "R11", "strobe in reset");
    rst_n = 1'b1;
  endtask

  initial begin
    int plens [3] = '{8, 12, 20};
    int dtas  [4] = '{0, 1, 2, 3};
    int dtcs  [4] = '{0, 3, 0, 1};
    int h;
    rst_n = 1'b0; period_len = 8'd8; phase_cmd = '0;
    dead_ab = '0; dead_cd = '0; force_low = 1'b0;

    // Sweep: period lengths x dead-time pairs x every phase command near the range.
    for (int pi = 0; pi < 3; pi++) begin
      h = plens[pi] / 2;
      do_reset(plens[pi]);
      for (int di = 0; di < 4; di++) begin
        for (int cmd = 0; cmd <= ZTH + h + 2; cmd++) begin
          string ra = (dtas[di] == 0) ? "R6" : ((dtas[di] != dtcs[di]) ? "R5" : "R3");
          string rc = (cmd < ZTH) ? "R7" : ((cmd - ZTH > h) ? "R8" : "R4");
          @(negedge clk);
          phase_cmd = PH_W'(cmd);
          dead_ab = DT_W'(dtas[di]);
          dead_cd = DT_W'(dtcs[di]);
          wait_ps();
          wait_ps();
          check_period(h, smap(cmd, h), dtas[di], dtcs[di], ra, rc);
        end
      end
    end

    // R9: command changed at the start of a period applies only from the next one.
    do_reset(12);
    h = 6;
    dead_ab = 4'd2; dead_cd = 4'd1; phase_cmd = PH_W'(ZTH + 2);
    wait_ps(); wait_ps();
    wait_ps();
    phase_cmd = PH_W'(ZTH + 5);
    check_period(h, 2, 2, 1, "R9", "R9");
    wait_ps();
    wait_ps();
    check_period(h, 5, 2, 1, "R9", "R9");

    // R10: force-low blanks all outputs, then switching recovers.
    @(negedge clk);
    force_low = 1'b1;
    for (int k = 0; k < 2 * h; k++) begin
      @(negedge clk);
      chk(out_a | out_b | out_c | out_d, 1'b0, "R10", $sformatf("outputs under force_low k=%0d", k));
    end
    force_low = 1'b0;
    wait_ps(); wait_ps();
    check_period(h, 5, 2, 1, "R10", "R10");

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule